// File: doc/BRIEF.md
# Four-Channel PWM Control and Interrupt Register Block

This block is the control plane of a small pulse-width modulation peripheral on a 32-bit memory-mapped register bus. It keeps a run bit and an interrupt-mask bit for each channel. Software changes these bits through separate set and clear strobe registers, so one channel can be changed without a read-modify-write. Each channel also has a window of configuration registers: a mode word, a duty value, a period value and a read-only view of its counter.

Each channel counts up on every cycle in which the external prescaled tick is high. When the counter reaches the period value it wraps to zero, and the channel raises a pending event. Pending events collect in a status register that clears itself when it is read. One interrupt line goes high while any pending event is unmasked. The output pin is high while the counter is below the duty value. Bit 0 of the channel's mode word inverts it. A stopped channel drives its pin low.

Top module: `pwmc_top`

## Requirements
- R1: After reset, every channel is stopped, every mask bit and pending flag is clear, all PWM outputs are low and the interrupt line is low.
- R2: Writing word offset 0x04 sets the run bit of each channel whose data bit is 1. Writing offset 0x08 clears the run bit of each channel whose data bit is 1. Zero data bits have no effect. Reading offset 0x0C returns the run bits in bits [3:0], and writes to 0x0C are ignored.
- R3: Writing offset 0x10 sets mask bits and writing offset 0x14 clears them, one bit per channel whose data bit is 1. Offset 0x18 reads the mask in bits [3:0], and writes to 0x18 are ignored.
- R4: A read of offset 0x1C returns the pending flags in bits [3:0] and clears them in the same access. A pending flag is set only by a channel's period-end event.
- R5: A period-end event that occurs in the same cycle as a read of offset 0x1C remains pending after the read.
- R6: The interrupt output is high exactly when some channel has both its pending flag and its mask bit set.
- R7: While a channel runs, its counter advances by one on each cycle with the tick high and holds when the tick is low. When the counter is at or above the period value on a tick, it wraps to 0 and raises that channel's period-end event. A stopped channel's counter is held at 0.
- R8: While a channel runs, its output is (counter < duty) XOR mode bit 0. While a channel is stopped, its output is low.
- R9: Channel n's window starts at 0x200 + n*0x20. The mode word is at +0x00 (4 bits stored), the duty is at +0x04 and the period is at +0x08 (16 bits each, upper write bits dropped). The counter is at +0x0C and is read-only. Unstored bits read as 0.
- R10: Offset 0x00 holds a 32-bit general mode word that reads back as written. A read of any unmapped address returns 0, and so does a read of a non-word-aligned address.
- R11: Read data appears on the read-data port in the cycle after the read strobe. It holds until the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_i | input | 1 | Prescaled count enable shared by all channels |
| bus_wr_i | input | 1 | Write strobe |
| bus_rd_i | input | 1 | Read strobe |
| bus_addr_i | input | 12 | Byte address |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Registered read data |
| pwm_o | output | 4 | Per-channel PWM outputs |
| irq_o | output | 1 | Combined interrupt |

## Verification
The bench times a status read to land on a period-end event of a channel whose period is zero. A design that lets the read win would drop that event, and the interrupt line would fall right after the read. It runs duty values of zero and above the period, with and without the inverting mode bit. An off-by-one compare or a late wrap would then show up as a wrong pin level in a specific cycle. Random sequences of set and clear strobes, with writes to the read-only registers mixed in, are checked against a bench model of the run and mask bits. This exposes set and clear registers that are swapped, that act on zero data bits, or that accept writes to read-only views. Reading a status register twice shows whether it clears on read, and reading an idle counter after a write to it shows whether it is truly read-only.

// File: rtl/pwmc_pkg.sv
package pwmc_pkg;
    localparam int BUS_W  = 32;
    localparam int ADDR_W = 12;

    // global register select; values equal address bits [4:2]
    typedef enum logic [3:0] {
        G_MODE  = 4'd0,
        G_EN    = 4'd1,
        G_DIS   = 4'd2,
        G_STAT  = 4'd3,
        G_IEN   = 4'd4,
        G_IDIS  = 4'd5,
        G_IMASK = 4'd6,
        G_ISR   = 4'd7,
        G_NONE  = 4'd8
    } greg_e;

    // channel register select; values equal address bits [3:2]
    typedef enum logic [1:0] {
        C_MODE = 2'd0,
        C_DUTY = 2'd1,
        C_PER  = 2'd2,
        C_CNT  = 2'd3
    } creg_e;
endpackage

// File: rtl/pwmc_decode.sv
module pwmc_decode
    import pwmc_pkg::*;
#(
    parameter int NCH = 4,
    parameter int CIW = 2
) (
    input  logic [ADDR_W-1:0] addr_i,
    output greg_e             gsel_o,
    output logic              chit_o,
    output logic [CIW-1:0]    cidx_o,
    output creg_e             creg_o
);
    localparam logic [3:0] NCH4 = 4'(NCH);

    logic       aligned;
    logic [3:0] win;

    always_comb begin
        aligned = (addr_i[1:0] == 2'b00);
        win     = addr_i[8:5];
        gsel_o  = G_NONE;
        if (aligned && addr_i[ADDR_W-1:5] == '0)
            gsel_o = greg_e'({1'b0, addr_i[4:2]});
        chit_o = aligned && (addr_i[ADDR_W-1:9] == 3'b001) && (win < NCH4)
                 && (addr_i[4] == 1'b0);
        cidx_o = win[CIW-1:0];
        creg_o = creg_e'(addr_i[3:2]);
    end
endmodule

// File: rtl/pwmc_ctrl.sv
module pwmc_ctrl
    import pwmc_pkg::*;
#(
    parameter int NCH = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_i,
    input  logic             rd_i,
    input  greg_e            sel_i,
    input  logic [BUS_W-1:0] wdata_i,
    input  logic [NCH-1:0]   evt_i,
    output logic [BUS_W-1:0] mode_o,
    output logic [NCH-1:0]   en_o,
    output logic [NCH-1:0]   mask_o,
    output logic [NCH-1:0]   pend_o,
    output logic             irq_o
);
    typedef struct packed {
        logic [BUS_W-1:0] mode;
        logic [NCH-1:0]   en;
        logic [NCH-1:0]   mask;
        logic [NCH-1:0]   pend;
    } ctrl_t;

    ctrl_t          st_d, st_q;
    logic [NCH-1:0] bits;
    logic           clr_rd;

    always_comb begin
        st_d   = st_q;
        bits   = wdata_i[NCH-1:0];
        clr_rd = rd_i && (sel_i == G_ISR);
        if (wr_i) begin
            case (sel_i)
                G_MODE:  st_d.mode = wdata_i;
                G_EN:    st_d.en   = st_q.en | bits;
                G_DIS:   st_d.en   = st_q.en & ~bits;
                G_IEN:   st_d.mask = st_q.mask | bits;
                G_IDIS:  st_d.mask = st_q.mask & ~bits;
                default: ;
            endcase
        end
        // a new event wins over the clear of the same cycle
        st_d.pend = (clr_rd ? '0 : st_q.pend) | evt_i;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign mode_o = st_q.mode;
    assign en_o   = st_q.en;
    assign mask_o = st_q.mask;
    assign pend_o = st_q.pend;
    assign irq_o  = |(st_q.pend & st_q.mask);

    assert_en_set_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_i && sel_i == G_EN) |=>
        ((en_o & $past(wdata_i[NCH-1:0])) == $past(wdata_i[NCH-1:0])));

    assert_dis_clr_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_i && sel_i == G_DIS) |=> ((en_o & $past(wdata_i[NCH-1:0])) == '0));

    assert_mask_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_i && (sel_i == G_IEN || sel_i == G_IDIS)) |=> $stable(mask_o));

    assert_read_clears_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_i && sel_i == G_ISR) |=> ((pend_o & ~$past(evt_i)) == '0));

    assert_event_kept_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_i != '0) |=> ((pend_o & $past(evt_i)) == $past(evt_i)));
endmodule

// File: rtl/pwmc_chan.sv
module pwmc_chan
    import pwmc_pkg::*;
#(
    parameter int CNT_W  = 16,
    parameter int MODE_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_i,
    input  logic              en_i,
    input  logic              wr_i,
    input  creg_e             creg_i,
    input  logic [CNT_W-1:0]  wdata_i,
    output logic [MODE_W-1:0] mode_o,
    output logic [CNT_W-1:0]  duty_o,
    output logic [CNT_W-1:0]  per_o,
    output logic [CNT_W-1:0]  cnt_o,
    output logic              evt_o,
    output logic              pwm_o
);
    typedef struct packed {
        logic [MODE_W-1:0] mode;
        logic [CNT_W-1:0]  duty;
        logic [CNT_W-1:0]  per;
        logic [CNT_W-1:0]  cnt;
    } chan_t;

    chan_t st_d, st_q;
    logic  evt;

    always_comb begin
        st_d = st_q;
        evt  = 1'b0;
        if (wr_i) begin
            case (creg_i)
                C_MODE:  st_d.mode = wdata_i[MODE_W-1:0];
                C_DUTY:  st_d.duty = wdata_i;
                C_PER:   st_d.per  = wdata_i;
                default: ;
            endcase
        end
        if (!en_i) begin
            st_d.cnt = '0;
        end else if (tick_i) begin
            if (st_q.cnt >= st_q.per) begin
                st_d.cnt = '0;
                evt      = 1'b1;
            end else begin
                st_d.cnt = st_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign mode_o = st_q.mode;
    assign duty_o = st_q.duty;
    assign per_o  = st_q.per;
    assign cnt_o  = st_q.cnt;
    assign evt_o  = evt;
    assign pwm_o  = en_i & ((st_q.cnt < st_q.duty) ^ st_q.mode[0]);

    assert_wrap_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (en_i && tick_i && cnt_o >= per_o) |=> (cnt_o == '0));

    assert_idle_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !en_i |=> (cnt_o == '0));

    assert_tick_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (en_i && !tick_i) |=> $stable(cnt_o));
endmodule

// File: rtl/pwmc_top.sv
module pwmc_top
    import pwmc_pkg::*;
#(
    parameter int NCH    = 4,
    parameter int CNT_W  = 16,
    parameter int MODE_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_i,
    input  logic              bus_wr_i,
    input  logic              bus_rd_i,
    input  logic [ADDR_W-1:0] bus_addr_i,
    input  logic [BUS_W-1:0]  bus_wdata_i,
    output logic [BUS_W-1:0]  bus_rdata_o,
    output logic [NCH-1:0]    pwm_o,
    output logic              irq_o
);
    localparam int CIW = (NCH > 1) ? $clog2(NCH) : 1;

    greg_e            gsel;
    creg_e            creg;
    logic             chit;
    logic [CIW-1:0]   cidx;
    logic [BUS_W-1:0] gmode;
    logic [NCH-1:0]   en, mask, pend, evt;
    logic [BUS_W-1:0] rdata_d, rdata_q;

    logic [MODE_W-1:0] mode_a [NCH];
    logic [CNT_W-1:0]  duty_a [NCH];
    logic [CNT_W-1:0]  per_a  [NCH];
    logic [CNT_W-1:0]  cnt_a  [NCH];

    pwmc_decode #(.NCH(NCH), .CIW(CIW)) u_dec (
        .addr_i (bus_addr_i),
        .gsel_o (gsel),
        .chit_o (chit),
        .cidx_o (cidx),
        .creg_o (creg)
    );

    pwmc_ctrl #(.NCH(NCH)) u_ctrl (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_i    (bus_wr_i),
        .rd_i    (bus_rd_i),
        .sel_i   (gsel),
        .wdata_i (bus_wdata_i),
        .evt_i   (evt),
        .mode_o  (gmode),
        .en_o    (en),
        .mask_o  (mask),
        .pend_o  (pend),
        .irq_o   (irq_o)
    );

    for (genvar i = 0; i < NCH; i++) begin : g_ch
        logic ch_wr;
        assign ch_wr = bus_wr_i && chit && (cidx == CIW'(i));
        pwmc_chan #(.CNT_W(CNT_W), .MODE_W(MODE_W)) u_ch (
            .clk     (clk),
            .rst_n   (rst_n),
            .tick_i  (tick_i),
            .en_i    (en[i]),
            .wr_i    (ch_wr),
            .creg_i  (creg),
            .wdata_i (bus_wdata_i[CNT_W-1:0]),
            .mode_o  (mode_a[i]),
            .duty_o  (duty_a[i]),
            .per_o   (per_a[i]),
            .cnt_o   (cnt_a[i]),
            .evt_o   (evt[i]),
            .pwm_o   (pwm_o[i])
        );
    end

    always_comb begin
        rdata_d = rdata_q;
        if (bus_rd_i) begin
            rdata_d = '0;
            if (gsel != G_NONE) begin
                case (gsel)
                    G_MODE:  rdata_d = gmode;
                    G_STAT:  rdata_d = BUS_W'(en);
                    G_IMASK: rdata_d = BUS_W'(mask);
                    G_ISR:   rdata_d = BUS_W'(pend);
                    default: rdata_d = '0;
                endcase
            end else if (chit) begin
                case (creg)
                    C_MODE:  rdata_d = BUS_W'(mode_a[cidx]);
                    C_DUTY:  rdata_d = BUS_W'(duty_a[cidx]);
                    C_PER:   rdata_d = BUS_W'(per_a[cidx]);
                    default: rdata_d = BUS_W'(cnt_a[cidx]);
                endcase
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) rdata_q <= '0;
        else        rdata_q <= rdata_d;
    end

    assign bus_rdata_o = rdata_q;

    assert_rdata_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_rd_i |=> $stable(bus_rdata_o));

    assert_irq_src_R6: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> ((pend & mask) != '0));
endmodule

// File: tb/pwmc_top_tb.sv
module pwmc_top_tb;
    localparam int CLK_NS = 20;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick = 1'b0;
    logic        wr = 1'b0;
    logic        rd = 1'b0;
    logic [11:0] addr = '0;
    logic [31:0] wdata = '0;
    wire  [31:0] rdata;
    wire  [3:0]  pwm;
    wire         irq;

    int n_run  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #(CLK_NS/2) clk = ~clk;

    pwmc_top u_dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .tick_i      (tick),
        .bus_wr_i    (wr),
        .bus_rd_i    (rd),
        .bus_addr_i  (addr),
        .bus_wdata_i (wdata),
        .bus_rdata_o (rdata),
        .pwm_o       (pwm),
        .irq_o       (irq)
    );

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic bw(logic [11:0] a, logic [31:0] d);
        @(negedge clk);
        wr = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr = 1'b0;
    endtask

    task automatic br(logic [11:0] a, output logic [31:0] d);
        @(negedge clk);
        rd = 1'b1; addr = a;
        @(negedge clk);
        rd = 1'b0;
        d = rdata;
    endtask

    function automatic logic [11:0] ch_addr(int c, int r);
        return 12'(12'h200 + c * 32 + r * 4);
    endfunction

    function automatic logic exp_pin(int k, int p, int d, bit pol);
        return ((k % (p + 1)) < d) ^ pol;
    endfunction

    task automatic run_pattern(int c, int p, int d, bit pol);
        bw(12'h008, 32'hF);
        bw(ch_addr(c, 0), {31'd0, pol});
        bw(ch_addr(c, 1), 32'(d));
        bw(ch_addr(c, 2), 32'(p));
        bw(12'h004, 32'(1 << c));
        for (int k = 0; k < 2 * (p + 1); k++) begin
            chk("R8 pin level", {31'd0, pwm[c]}, {31'd0, exp_pin(k, p, d, pol)});
            @(negedge clk);
        end
        chk("R8 other pins low", 32'(pwm & ~(4'd1 << c)), 32'd0);
        bw(12'h008, 32'(1 << c));
        chk("R8 stopped pin low", {31'd0, pwm[c]}, 32'd0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog: actual hung expected done");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        logic [31:0] v, v2;
        logic [3:0]  m_en, m_mask;
        void'($urandom(32'd2024));
        repeat (5) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        chk("R1 pwm", 32'(pwm), 32'd0);
        chk("R1 irq", {31'd0, irq}, 32'd0);
        br(12'h00C, v); chk("R1 status", v, 32'd0);
        br(12'h018, v); chk("R1 mask", v, 32'd0);
        br(12'h01C, v); chk("R1 pending", v, 32'd0);

        // R10 general mode word, unmapped and misaligned
        bw(12'h000, 32'hA5A5_1234);
        br(12'h000, v); chk("R10 mode word", v, 32'hA5A5_1234);
        br(12'h100, v); chk("R10 unmapped", v, 32'd0);
        br(12'h280, v); chk("R10 no channel 4", v, 32'd0);
        br(12'h002, v); chk("R10 misaligned", v, 32'd0);

        // R9 channel window
        bw(ch_addr(3, 0), 32'hFF);
        bw(ch_addr(3, 1), 32'h0001_2345);
        bw(ch_addr(3, 2), 32'h0003_00AB);
        bw(ch_addr(3, 3), 32'h0000_7777);
        br(ch_addr(3, 0), v); chk("R9 mode", v, 32'hF);
        br(ch_addr(3, 1), v); chk("R9 duty", v, 32'h2345);
        br(ch_addr(3, 2), v); chk("R9 period", v, 32'h00AB);
        br(ch_addr(3, 3), v); chk("R9 counter read-only", v, 32'd0);
        br(ch_addr(2, 1), v); chk("R9 other channel", v, 32'd0);

        // R11 read data holds
        br(ch_addr(3, 1), v);
        repeat (3) @(negedge clk);
        chk("R11 hold", rdata, 32'h2345);

        // R2 / R3 random strobes, tick low so no events
        m_en = '0; m_mask = '0;
        for (int i = 0; i < 120; i++) begin
            int op;
            logic [3:0] d;
            op = int'($urandom % 6);
            d  = 4'($urandom);
            case (op)
                0: begin bw(12'h004, 32'(d)); m_en = m_en | d; end
                1: begin bw(12'h008, 32'(d)); m_en = m_en & ~d; end
                2: begin bw(12'h010, 32'(d)); m_mask = m_mask | d; end
                3: begin bw(12'h014, 32'(d)); m_mask = m_mask & ~d; end
                4: bw(12'h018, 32'(d));
                default: bw(12'h00C, 32'(d));
            endcase
            br(12'h00C, v);  chk("R2 run bits", v, 32'(m_en));
            br(12'h018, v2); chk("R3 mask bits", v2, 32'(m_mask));
        end
        bw(12'h008, 32'hF);
        bw(12'h014, 32'hF);
        br(12'h018, v); chk("R3 mask cleared", v, 32'd0);

        // R8 / R7 waveforms
        tick = 1'b1;
        run_pattern(0, 5, 2, 1'b0);
        run_pattern(1, 4, 0, 1'b0);
        run_pattern(2, 3, 4, 1'b0);
        run_pattern(3, 6, 3, 1'b1);
        run_pattern(0, 0, 1, 1'b0);
        for (int i = 0; i < 4; i++) begin
            int p, d;
            p = 1 + int'($urandom % 12);
            d = int'($urandom % (p + 2));
            run_pattern(int'($urandom % 4), p, d, 1'($urandom));
        end

        // R7 tick hold
        tick = 1'b0;
        bw(ch_addr(0, 2), 32'd100);
        bw(12'h004, 32'h1);
        tick = 1'b1;
        repeat (3) @(negedge clk);
        tick = 1'b0;
        repeat (4) @(negedge clk);
        br(ch_addr(0, 3), v); chk("R7 counter holds", v, 32'd3);
        bw(12'h008, 32'h1);
        br(ch_addr(0, 3), v); chk("R7 stopped counter zero", v, 32'd0);

        // R4 / R6 clear on read and interrupt gating
        tick = 1'b1;
        br(12'h01C, v);
        bw(ch_addr(2, 1), 32'd1);
        bw(ch_addr(2, 2), 32'd3);
        bw(12'h004, 32'h4);
        repeat (6) @(negedge clk);
        bw(12'h008, 32'h4);
        chk("R6 masked irq low", {31'd0, irq}, 32'd0);
        bw(12'h010, 32'h4);
        chk("R6 irq high", {31'd0, irq}, 32'd1);
        br(12'h01C, v); chk("R4 pending read", v, 32'h4);
        chk("R6 irq low after clear", {31'd0, irq}, 32'd0);
        br(12'h01C, v); chk("R4 cleared", v, 32'd0);

        // R5 event coincident with read
        bw(ch_addr(1, 2), 32'd0);
        bw(12'h010, 32'h2);
        bw(12'h004, 32'h2);
        repeat (2) @(negedge clk);
        br(12'h01C, v); chk("R5 pending seen", 32'(v[1]), 32'd1);
        chk("R5 event kept irq", {31'd0, irq}, 32'd1);
        bw(12'h008, 32'h2);
        br(12'h01C, v); chk("R5 still pending", v, 32'h2);
        br(12'h01C, v); chk("R4 empty after stop", v, 32'd0);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule